// File: doc/BRIEF.md
# Routed 32-Source Interrupt Controller

This block gathers thirty-two interrupt request inputs, captures each in a pending flag, and forwards every enabled flag to one of seven processor interrupt lines. Each source has its own 4-bit setting: the upper bit turns the source on, and the lower three bits choose which line it drives. A line is asserted whenever at least one pending source is enabled and routed to it. Any source can be sent to any line.

Software reaches the controller through a 32-bit register bus that reads and writes whole words. Four control words hold the settings for eight sources each. A write-one-to-clear word removes pending flags. A read-only status word shows all thirty-two raw pending flags. A request that is still high after software clears it sets its flag again. Software must therefore quiet the device that raised the request before the flag will stay clear.

Top module: `irq_router_ctrl`

## Requirements
- R1: After reset every control word reads zero, the status word reads zero and all seven output lines are low.
- R2: A request input that is high on a rising clock edge sets its pending flag. The flag appears in the status word (word index 5, bit n for source n) and stays set after the request falls.
- R3: Writing the clear word (word index 4) clears every pending flag whose bit is 1 in the written data. Flags written with 0 are left unchanged, and the clear word always reads zero.
- R4: When a request is high in the same cycle its flag is cleared, the flag stays set. A level request therefore survives a clear.
- R5: Control words sit at word indices 0 to 3, and source n uses word n/8. Its field is bits [(n mod 8)*4+3 : (n mod 8)*4], with bit 3 of the field as the enable and bits 2:0 as the line number. Each control word reads back exactly the 32 bits last written to it.
- R6: Output line k (0 to 6) is high exactly when some source has its pending flag set, its enable bit set and line number k.
- R7: A source whose enable bit is 0 drives no line, even with its flag pending. Setting the enable bit later makes the pending source drive its line.
- R8: Line numbers 5 and 7 are reserved. An enabled pending source routed to either one drives no output line, and line 5 stays low.
- R9: The status word is read-only: writing it changes no pending flag.
- R10: Word indices 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr, valid in the same cycle |
| irq_req_i | input | 32 | Interrupt request inputs, one per source |
| irq_line_o | output | 7 | Processor interrupt lines |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a live request to the same source. The bench raises request 17 and writes its clear bit on the same falling edge, so both are sampled by one rising edge. It then confirms through the status word that the flag survived. The bench also leaves a flag pending while the source is disabled, then enables the source, to show that the enable gates only the output and never the capture.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned FIELD_W     = 4;
  localparam int unsigned LINE_SEL_W  = 3;
  localparam int unsigned CTRL_WORDS  = 4;
  localparam int unsigned CLR_WORD    = 4;
  localparam int unsigned STAT_WORD   = 5;
  localparam int unsigned NUM_LINES_D = 7;
  localparam int unsigned RSVD_LINE_D = 5;

  typedef struct packed {
    logic                  en;
    logic [LINE_SEL_W-1:0] sel;
  } route_fld_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [CTRL_WORDS*DATA_W-1:0] ctrl_flat,
  output logic                         clr_valid,
  output logic [DATA_W-1:0]            clr_mask
);
  logic [DATA_W-1:0] ctrl_q  [CTRL_WORDS];
  logic [DATA_W-1:0] ctrl_d  [CTRL_WORDS];
  logic              ctrl_we [CTRL_WORDS];

  genvar gi;
  generate
    for (gi = 0; gi < CTRL_WORDS; gi++) begin : g_word
      localparam logic [ADDR_W-1:0] WIDX = ADDR_W'(gi);

      always_comb begin
        ctrl_we[gi] = wr_en && (addr == WIDX);
        ctrl_d[gi]  = ctrl_we[gi] ? wdata : ctrl_q[gi];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ctrl_q[gi] <= '0;
        else if (ctrl_we[gi]) ctrl_q[gi] <= ctrl_d[gi];
      end

      assign ctrl_flat[gi*DATA_W +: DATA_W] = ctrl_q[gi];
    end
  endgenerate

  localparam logic [ADDR_W-1:0] CLR_IDX = ADDR_W'(CLR_WORD);

  always_comb begin
    clr_valid = wr_en && (addr == CLR_IDX);
    clr_mask  = clr_valid ? wdata : '0;
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               clr_valid,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] kill;

  always_comb begin
    kill   = clr_valid ? clr_mask : '0;
    // new requests are merged after the clear so a live request survives
    pend_d = (pend_q & ~kill) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned NUM_LINES = NUM_LINES_D,
  parameter int unsigned RSVD_LINE = RSVD_LINE_D
) (
  input  logic [NUM_SRC-1:0]         pend,
  input  logic [NUM_SRC*FIELD_W-1:0] fields,
  output logic [NUM_LINES-1:0]       lines
);
  route_fld_t         fld [NUM_SRC];
  logic [NUM_SRC-1:0] live;

  genvar gs, gk;
  generate
    for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
      assign fld[gs]  = route_fld_t'(fields[gs*FIELD_W +: FIELD_W]);
      assign live[gs] = pend[gs] & fld[gs].en;
    end

    for (gk = 0; gk < NUM_LINES; gk++) begin : g_line
      if (gk == RSVD_LINE) begin : g_rsvd
        assign lines[gk] = 1'b0;
      end else begin : g_used
        localparam logic [LINE_SEL_W-1:0] KSEL = LINE_SEL_W'(gk);
        logic [NUM_SRC-1:0] hit;
        for (gs = 0; gs < NUM_SRC; gs++) begin : g_hit
          assign hit[gs] = live[gs] & (fld[gs].sel == KSEL);
        end
        assign lines[gk] = |hit;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned NUM_LINES = NUM_LINES_D
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_SRC-1:0]   irq_req_i,
  output logic [NUM_LINES-1:0] irq_line_o
);
  localparam int unsigned CTRL_BITS = CTRL_WORDS * DATA_W;

  logic                 rst_sync_n;
  logic [CTRL_BITS-1:0] ctrl_flat;
  logic                 clr_valid;
  logic [DATA_W-1:0]    clr_mask;
  logic [NUM_SRC-1:0]   pend_q;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .ctrl_flat (ctrl_flat),
    .clr_valid (clr_valid),
    .clr_mask  (clr_mask)
  );

  irq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (irq_req_i),
    .clr_valid (clr_valid),
    .clr_mask  (clr_mask[NUM_SRC-1:0]),
    .pend      (pend_q)
  );

  irq_route_mux #(.NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES)) u_mux (
    .pend   (pend_q),
    .fields (ctrl_flat[NUM_SRC*FIELD_W-1:0]),
    .lines  (irq_line_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < ADDR_W'(CTRL_WORDS)) begin
      bus_rdata = ctrl_flat[bus_addr*DATA_W +: DATA_W];
    end else if (bus_addr == ADDR_W'(STAT_WORD)) begin
      bus_rdata = DATA_W'(pend_q);
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned NUM_LINES = 7
) (
  input logic                 clk,
  input logic                 rst_sn,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [NUM_SRC-1:0]   irq_req_i,
  input logic [NUM_SRC-1:0]   pend_q,
  input logic [NUM_LINES-1:0] irq_line_o
);
  logic               clr_hit;
  logic [NUM_SRC-1:0] clr_bits;

  assign clr_hit  = bus_wr && (bus_addr == ADDR_W'(4));
  assign clr_bits = clr_hit ? bus_wdata[NUM_SRC-1:0] : '0;

  assert_pend_sets_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (|irq_req_i) |=> ((pend_q & $past(irq_req_i)) == $past(irq_req_i)));

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (!(|irq_req_i)) |=> ((pend_q & ~$past(pend_q)) == '0));

  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    clr_hit |=> ((pend_q & $past(clr_bits & ~irq_req_i)) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (clr_hit && (|(clr_bits & irq_req_i)))
      |=> ((pend_q & $past(clr_bits & irq_req_i)) == $past(clr_bits & irq_req_i)));

  assert_line_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (|irq_line_o) |-> (|pend_q));
endmodule

bind irq_router_ctrl irq_router_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)
) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .irq_req_i  (irq_req_i),
  .pend_q     (pend_q),
  .irq_line_o (irq_line_o)
);

// File: tb/irq_router_ctrl_tb.sv
`timescale 1ns/1ps
module irq_router_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_req_i = '0;
  logic [6:0]  irq_line_o;

  int total = 0;
  int bad   = 0;
  logic [31:0] shadow [4];

  always #4 clk = ~clk;

  irq_router_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req_i(irq_req_i), .irq_line_o(irq_line_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk);
    irq_req_i = m;
    @(negedge clk);
    irq_req_i = '0;
  endtask

  task automatic set_route(input int src, input logic [2:0] line, input logic en);
    shadow[src/8][(src%8)*4 +: 4] = {en, line};
    wr(3'(src/8), shadow[src/8]);
  endtask

  task automatic wipe();
    for (int i = 0; i < 4; i++) begin
      shadow[i] = '0;
      wr(3'(i), '0);
    end
    wr(3'd4, 32'hFFFF_FFFF);
  endtask

  task automatic chk_lines(input logic [6:0] exp, input string tag);
    #1 chk(irq_line_o === exp, tag, 32'(irq_line_o), 32'(exp));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), d);
      chk(d === 32'h0, "R1 ctrl word zero", d, 32'h0);
    end
    rd(3'd5, d);
    chk(d === 32'h0, "R1 status zero", d, 32'h0);
    chk_lines(7'h00, "R1 lines low");
  endtask

  task automatic t_readback();
    logic [31:0] d;
    logic [31:0] pat [4];
    pat[0] = 32'hDEAD_BEEF; pat[1] = 32'h0123_4567;
    pat[2] = 32'hFFFF_FFFF; pat[3] = 32'h8000_0001;
    for (int i = 0; i < 4; i++) wr(3'(i), pat[i]);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), d);
      chk(d === pat[i], "R5 readback", d, pat[i]);
    end
    rd(3'd6, d); chk(d === 32'h0, "R10 word6 zero", d, 32'h0);
    rd(3'd7, d); chk(d === 32'h0, "R10 word7 zero", d, 32'h0);
    wipe();
  endtask

  task automatic t_route();
    logic [31:0] d;
    set_route(3, 3'd2, 1'b1);
    set_route(17, 3'd6, 1'b1);
    set_route(31, 3'd0, 1'b1);
    rd(3'd0, d); chk(d === 32'h0000_A000, "R5 src3 field", d, 32'h0000_A000);
    pulse(32'h1 << 3);
    rd(3'd5, d); chk(d === 32'h0000_0008, "R2 status after pulse", d, 32'h8);
    chk_lines(7'b0000100, "R6 src3 on line2");
    pulse(32'h1 << 17);
    chk_lines(7'b1000100, "R6 src17 on line6");
    pulse(32'h1 << 31);
    chk_lines(7'b1000101, "R6 src31 on line0");
    wr(3'd4, 32'h1 << 3);
    rd(3'd5, d); chk(d === 32'h8002_0000, "R3 selective clear", d, 32'h8002_0000);
    chk_lines(7'b1000001, "R3 line2 drops");
    rd(3'd4, d); chk(d === 32'h0, "R3 clear reads zero", d, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd5, d); chk(d === 32'h0, "R3 clear all", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk);
    irq_req_i = 32'h1 << 17;
    bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h1 << 17;
    @(negedge clk);
    bus_wr = 1'b0; irq_req_i = '0;
    rd(3'd5, d); chk(d === 32'h0002_0000, "R4 set beats clear", d, 32'h0002_0000);
    chk_lines(7'b1000000, "R4 line6 still high");
    wr(3'd4, 32'h1 << 17);
    rd(3'd5, d); chk(d === 32'h0, "R4 clear after release", d, 32'h0);
    wipe();
  endtask

  task automatic t_enable();
    logic [31:0] d;
    set_route(9, 3'd1, 1'b0);
    pulse(32'h1 << 9);
    rd(3'd5, d); chk(d === 32'h0000_0200, "R7 disabled still pends", d, 32'h200);
    chk_lines(7'b0000000, "R7 disabled drives nothing");
    set_route(9, 3'd1, 1'b1);
    chk_lines(7'b0000010, "R7 enable exposes pending");
    wipe();
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    set_route(20, 3'd5, 1'b1);
    set_route(21, 3'd7, 1'b1);
    pulse(32'h0030_0000);
    rd(3'd5, d); chk(d === 32'h0030_0000, "R8 pending set", d, 32'h0030_0000);
    chk_lines(7'b0000000, "R8 reserved routes drive nothing");
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); chk(d === 32'h0030_0000, "R9 status write ignored", d, 32'h0030_0000);
    wr(3'd5, 32'h0);
    rd(3'd5, d); chk(d === 32'h0030_0000, "R9 status zero write ignored", d, 32'h0030_0000);
    wipe();
  endtask

  initial begin : watchdog
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_route();
    t_set_wins();
    t_enable();
    t_reserved();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule